// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the command front end for a page-organized serial flash model. A host drives 32-bit command frames over a four-wire SPI slave link (SPI mode 0 or mode 3, MSB first). The block samples the serial lines with the system clock and captures the frame. When chip select goes high again, it decides what the frame means. A frame can start a self-timed array operation, be refused, or be dropped.

Array-type operations run one at a time. A busy flag marks the active operation, and a down-counter stands in for the internal program timer. The counter is loaded at launch with a cycle count that depends on the operation type. Buffer reads, buffer writes and status reads use no array, so they never collide with it. They are accepted at any time and leave the sequencer untouched.

Program-type commands that target the lowest quarter of the page space are refused while the write-protect input is low. Each launch gives a one-cycle start strobe, along with the operation kind, the page number and the buffer it uses. Each refusal gives a one-cycle rejected pulse.

Top module: `serial_flash_cmd_seq`

## Requirements
- R1: A frame is captured MSB first on rising SCK edges while chip select is low. Bits 31..24 are the opcode, bits 23..19 are ignored, bits 18..9 are the page number, and bits 8..0 are ignored. An accepted array command reports that page on `op_page`.
- R2: Array opcodes map to `op_kind` and `op_buf` as follows (`op_buf` 0 = first buffer, 1 = second buffer). 53h/55h give kind 1 (page to buffer copy). 60h/61h give kind 2 (page compare). 83h/86h give kind 3 (program with erase). 88h/89h give kind 4 (program without erase). 82h/85h give kind 5 (page program through buffer). 58h/59h give kind 6 (auto rewrite). In each pair, the first opcode selects buffer 0 and the second selects buffer 1.
- R3: An array operation starts only after chip select rises. `op_start` is high for exactly one cycle, and `busy` rises in that same cycle.
- R4: `busy` stays high for exactly the parameter cycle count that belongs to the launched kind, and then falls with no further input.
- R5: An array command that arrives while `busy` is high gives a one-cycle `cmd_rejected` pulse. It gives no `op_start`, and the running operation's busy time is unchanged.
- R6: Buffer read (54h/56h), buffer write (84h/87h) and status read (57h) frames give neither `op_start` nor `cmd_rejected`. This holds whether or not the block is busy, and `busy` is left unchanged.
- R7: With `wp_n` low, kinds 3, 4, 5 and 6 aimed at pages 0..255 are rejected. Kinds 1 and 2 are not affected, and pages 256 and up are not affected. With `wp_n` high, all pages are accepted.
- R8: A frame with fewer than 32 bits is dropped when chip select rises. Bits after the 32nd are ignored, and the first 32 bits decide the command.
- R9: Frames sent in mode 3 (SCK idle high) give the same results as frames sent in mode 0.
- R10: After reset, `busy`, `op_start` and `cmd_rejected` are 0, and `op_kind`, `op_page` and `op_buf` are 0.
- R11: A frame with an opcode not listed in R2 or R6 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write protect for the lowest page quarter |
| busy | output | 1 | Array operation in progress |
| op_start | output | 1 | One-cycle launch strobe |
| op_kind | output | 3 | Kind of the last launched operation |
| op_page | output | 10 | Page of the last launched operation |
| op_buf | output | 1 | Buffer of the last launched operation |
| cmd_rejected | output | 1 | One-cycle pulse for a refused command |

## Verification
Some rules are checked by assertions on every cycle. Start and reject never coincide, and a start never happens while the previous cycle was busy. `busy` rises only together with a start. A protected-page program never starts while write protect is low. The bit counter stays bounded and clears while chip select is high, and busy can only fall once the timer expires. Other behaviour can only be shown by the bench's scenarios. These include the opcode-to-kind and buffer mapping, the captured page value, the exact busy length for each kind, and the dropping of short frames and unknown opcodes. They also include the silence of buffer-group commands during busy and the equal handling of mode 0 and mode 3.

// File: rtl/sfcs_pkg.sv
package sfcs_pkg;

    localparam int FRAME_W = 32;
    localparam int OPC_W   = 8;
    localparam int PAGE_W  = 10;
    localparam int TAIL_W  = 9;   // ignored bits below the page field

    typedef enum logic [2:0] {
        K_NONE      = 3'd0,
        K_XFER      = 3'd1,
        K_COMPARE   = 3'd2,
        K_PGM_ERASE = 3'd3,
        K_PGM_KEEP  = 3'd4,
        K_MM_PGM    = 3'd5,
        K_REWRITE   = 3'd6
    } op_kind_e;

    typedef enum logic [1:0] {
        G_NONE   = 2'd0,
        G_ARRAY  = 2'd1,
        G_BUFFER = 2'd2
    } op_group_e;

    typedef struct packed {
        op_kind_e  kind;
        op_group_e grp;
        logic      buf_sel;
        logic      prog;
    } cmd_info_t;

    function automatic cmd_info_t decode_opcode(input logic [OPC_W-1:0] opc);
        cmd_info_t r;
        r = '{kind: K_NONE, grp: G_NONE, buf_sel: 1'b0, prog: 1'b0};
        case (opc)
            8'h53, 8'h55: begin r.kind = K_XFER;      r.grp = G_ARRAY; r.buf_sel = (opc == 8'h55); end
            8'h60, 8'h61: begin r.kind = K_COMPARE;   r.grp = G_ARRAY; r.buf_sel = (opc == 8'h61); end
            8'h83, 8'h86: begin r.kind = K_PGM_ERASE; r.grp = G_ARRAY; r.buf_sel = (opc == 8'h86); r.prog = 1'b1; end
            8'h88, 8'h89: begin r.kind = K_PGM_KEEP;  r.grp = G_ARRAY; r.buf_sel = (opc == 8'h89); r.prog = 1'b1; end
            8'h82, 8'h85: begin r.kind = K_MM_PGM;    r.grp = G_ARRAY; r.buf_sel = (opc == 8'h85); r.prog = 1'b1; end
            8'h58, 8'h59: begin r.kind = K_REWRITE;   r.grp = G_ARRAY; r.buf_sel = (opc == 8'h59); r.prog = 1'b1; end
            8'h54, 8'h56, 8'h84, 8'h87, 8'h57: r.grp = G_BUFFER;
            default: r.grp = G_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfcs_spi_capture.sv
module sfcs_spi_capture
    import sfcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              frame_end_o,
    output logic              frame_full_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [PAGE_W-1:0] page_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [2:0]         sck;   // [0] meta, [1] stable, [2] previous
        logic [2:0]         cs;
        logic [1:0]         mosi;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } cap_t;

    cap_t cap_d, cap_q;
    logic sck_rise;
    logic cs_low;
    logic unused_bits;

    always_comb begin
        cap_d      = cap_q;
        cap_d.sck  = {cap_q.sck[1:0], sck_i};
        cap_d.cs   = {cap_q.cs[1:0], cs_n_i};
        cap_d.mosi = {cap_q.mosi[0], mosi_i};
        sck_rise   = cap_q.sck[1] & ~cap_q.sck[2];
        cs_low     = ~cap_q.cs[1];
        if (!cs_low) begin
            cap_d.cnt = '0;
        end else if (sck_rise && (cap_q.cnt != CNT_W'(FRAME_W))) begin
            cap_d.sh  = {cap_q.sh[FRAME_W-2:0], cap_q.mosi[1]};
            cap_d.cnt = cap_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{sck: 3'b000, cs: 3'b111, mosi: 2'b00, cnt: '0, sh: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign frame_end_o  = cap_q.cs[1] & ~cap_q.cs[2];
    assign frame_full_o = (cap_q.cnt == CNT_W'(FRAME_W));
    assign opcode_o     = cap_q.sh[FRAME_W-1 -: OPC_W];
    assign page_o       = cap_q.sh[TAIL_W +: PAGE_W];
    assign unused_bits  = ^{cap_q.sh[FRAME_W-OPC_W-1:TAIL_W+PAGE_W], cap_q.sh[TAIL_W-1:0]};

    // R8: the bit counter saturates at the frame length
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.cnt <= CNT_W'(FRAME_W));

    // R1: with chip select high the frame counter is cleared
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.cs[1] |=> (cap_q.cnt == '0));

endmodule

// File: rtl/sfcs_cmd_decode.sv
module sfcs_cmd_decode
    import sfcs_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output cmd_info_t        info_o
);
    always_comb begin
        info_o = decode_opcode(opcode_i);
    end
endmodule

// File: rtl/sfcs_op_timer.sv
module sfcs_op_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (launch_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load_i;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;

    // R5: the sequencer never relaunches while an operation runs
    p_single_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !tmr_q.busy);

    // R4: busy ends only when the countdown has expired
    p_fall_at_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.busy) |-> ($past(tmr_q.cnt) == CNT_W'(1)));

    p_busy_has_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (tmr_q.cnt != '0));

endmodule

// File: rtl/serial_flash_cmd_seq.sv
module serial_flash_cmd_seq
    import sfcs_pkg::*;
#(
    parameter int T_XFER      = 300,
    parameter int T_COMPARE   = 320,
    parameter int T_PGM_ERASE = 900,
    parameter int T_PGM_KEEP  = 700,
    parameter int T_MM_PGM    = 1000,
    parameter int T_REWRITE   = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              wp_n,
    output logic              busy,
    output logic              op_start,
    output logic [2:0]        op_kind,
    output logic [PAGE_W-1:0] op_page,
    output logic              op_buf,
    output logic              cmd_rejected
);
    localparam int T_M1  = (T_XFER > T_COMPARE) ? T_XFER : T_COMPARE;
    localparam int T_M2  = (T_PGM_ERASE > T_PGM_KEEP) ? T_PGM_ERASE : T_PGM_KEEP;
    localparam int T_M3  = (T_MM_PGM > T_REWRITE) ? T_MM_PGM : T_REWRITE;
    localparam int T_M12 = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX = (T_M12 > T_M3) ? T_M12 : T_M3;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [1:0]        wp;     // [0] meta, [1] stable
        logic              start;
        logic              reject;
        op_kind_e          kind;
        logic [PAGE_W-1:0] page;
        logic              buf_sel;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              frame_end;
    logic              frame_full;
    logic [OPC_W-1:0]  opcode;
    logic [PAGE_W-1:0] page;
    cmd_info_t         info;
    logic              array_req;
    logic              prot_hit;
    logic              launch;
    logic [CNT_W-1:0]  load_val;

    sfcs_spi_capture u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_i        (spi_sck),
        .cs_n_i       (spi_cs_n),
        .mosi_i       (spi_mosi),
        .frame_end_o  (frame_end),
        .frame_full_o (frame_full),
        .opcode_o     (opcode),
        .page_o       (page)
    );

    sfcs_cmd_decode u_decode (
        .opcode_i (opcode),
        .info_o   (info)
    );

    always_comb begin
        // lowest quarter of the page space: two top page bits are zero
        prot_hit  = info.prog && !seq_q.wp[1] && (page[PAGE_W-1 -: 2] == 2'b00);
        array_req = frame_end && frame_full && (info.grp == G_ARRAY);
        launch    = array_req && !busy && !prot_hit;
        case (info.kind)
            K_XFER:      load_val = CNT_W'(T_XFER);
            K_COMPARE:   load_val = CNT_W'(T_COMPARE);
            K_PGM_ERASE: load_val = CNT_W'(T_PGM_ERASE);
            K_PGM_KEEP:  load_val = CNT_W'(T_PGM_KEEP);
            K_MM_PGM:    load_val = CNT_W'(T_MM_PGM);
            K_REWRITE:   load_val = CNT_W'(T_REWRITE);
            default:     load_val = CNT_W'(1);
        endcase

        seq_d        = seq_q;
        seq_d.wp     = {seq_q.wp[0], wp_n};
        seq_d.start  = launch;
        seq_d.reject = array_req && (busy || prot_hit);
        if (launch) begin
            seq_d.kind    = info.kind;
            seq_d.page    = page;
            seq_d.buf_sel = info.buf_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{wp: 2'b11, start: 1'b0, reject: 1'b0, kind: K_NONE, page: '0, buf_sel: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    sfcs_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .load_i   (load_val),
        .busy_o   (busy)
    );

    assign op_start     = seq_q.start;
    assign cmd_rejected = seq_q.reject;
    assign op_kind      = seq_q.kind;
    assign op_page      = seq_q.page;
    assign op_buf       = seq_q.buf_sel;

    p_start_xor_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_start && cmd_rejected));

    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    p_busy_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> op_start);

    p_start_idle_before_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(busy));

    p_reject_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rejected |=> !cmd_rejected);

    p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && (op_kind >= 3'd3) && (op_page[PAGE_W-1 -: 2] == 2'b00)) |-> $past(seq_q.wp[1]));

endmodule

// File: tb/test_serial_flash_cmd_seq.sv
module test_serial_flash_cmd_seq;

    localparam int D_XFER = 300, D_CMP = 320, D_PE = 900, D_PK = 700, D_MM = 1000, D_RW = 1200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, wp_n = 1'b1;
    logic busy, op_start, op_buf, cmd_rejected;
    logic [2:0] op_kind;
    logic [9:0] op_page;

    always #2 clk = ~clk;

    serial_flash_cmd_seq #(
        .T_XFER(D_XFER), .T_COMPARE(D_CMP), .T_PGM_ERASE(D_PE),
        .T_PGM_KEEP(D_PK), .T_MM_PGM(D_MM), .T_REWRITE(D_RW)
    ) i_serial_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .wp_n(wp_n), .busy(busy), .op_start(op_start),
        .op_kind(op_kind), .op_page(op_page), .op_buf(op_buf),
        .cmd_rejected(cmd_rejected)
    );

    typedef struct {
        bit         is_start;
        logic [2:0] kind;
        logic [9:0] page;
        logic       bsel;
        int         dur;
        string      req;
    } exp_t;

    exp_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_start(input logic [2:0] k, input logic [9:0] p, input logic b, input int d, input string req);
        exp_t e;
        e.is_start = 1; e.kind = k; e.page = p; e.bsel = b; e.dur = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic expect_reject(input string req);
        exp_t e;
        e.is_start = 0; e.kind = 0; e.page = 0; e.bsel = 0; e.dur = 0; e.req = req;
        sb.push_back(e);
    endtask

    // Sends nbits of {opcode, 5 zero bits, page, 9 zero bits, zero padding}
    task automatic spi_send(input logic [7:0] opc, input logic [9:0] pg, input int nbits, input bit mode3);
        logic [63:0] word;
        word = {opc, 5'b0, pg, 9'b0, 32'b0};
        spi_sck = mode3;
        tick(6);
        spi_cs_n = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = word[63-i];
            tick(4);
            spi_sck = 1'b1;
            tick(4);
        end
        if (!mode3) spi_sck = 1'b0;
        tick(4);
        spi_cs_n = 1'b1;
        tick(12);
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
        tick(8);
    endtask

    // Scoreboard monitor
    int  meas = 0;
    int  meas_exp = 0;
    bit  measuring = 0;
    string meas_req;
    always @(negedge clk) begin
        if (rst_n) begin
            if (measuring) begin
                if (busy) meas++;
                else begin
                    check(meas == meas_exp, meas_req,
                          $sformatf("busy length act=%0d exp=%0d", meas, meas_exp));
                    measuring = 0;
                end
            end
            if (op_start || cmd_rejected) begin
                if (sb.size() == 0) begin
                    check(0, "R5/R6/R8/R11", $sformatf("unexpected event start=%0d reject=%0d exp=none",
                          op_start, cmd_rejected));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.is_start) begin
                        check(op_start && op_kind == e.kind && op_page == e.page && op_buf == e.bsel && busy, e.req,
                              $sformatf("start=%0d kind=%0d page=%0d buf=%0d busy=%0d exp start kind=%0d page=%0d buf=%0d",
                                        op_start, op_kind, op_page, op_buf, busy, e.kind, e.page, e.bsel));
                        measuring = 1; meas = 1; meas_exp = e.dur; meas_req = e.req;
                    end else begin
                        check(cmd_rejected && !op_start, e.req,
                              $sformatf("reject=%0d start=%0d exp reject=1 start=0", cmd_rejected, op_start));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R10: reset state
        check(!busy && !op_start && !cmd_rejected, "R10",
              $sformatf("busy=%0d start=%0d rej=%0d exp 0", busy, op_start, cmd_rejected));
        check(op_kind == 0 && op_page == 0 && op_buf == 0, "R10",
              $sformatf("kind=%0d page=%0d buf=%0d exp 0", op_kind, op_page, op_buf));
        rst_n = 1'b1;
        tick(5);

        // R1 R2 R3 R4: auto rewrite through buffer 0
        expect_start(3'd6, 10'd300, 1'b0, D_RW, "R1");
        spi_send(8'h58, 10'd300, 32, 0);
        // R6: buffer-group frames during busy
        spi_send(8'h57, 10'd0, 8, 0);
        spi_send(8'h84, 10'd12, 32, 0);
        check(busy == 1'b1 && sb.size() == 0, "R6", $sformatf("busy=%0d pending=%0d exp busy=1 pending=0", busy, sb.size()));
        // R5: array command while busy
        expect_reject("R5");
        spi_send(8'h53, 10'd7, 32, 0);
        check(busy == 1'b1, "R5", $sformatf("busy=%0d exp 1", busy));
        wait_idle();

        // R9 R2: mode 3, second buffer, top page
        expect_start(3'd6, 10'd1023, 1'b1, D_RW, "R9");
        spi_send(8'h59, 10'd1023, 32, 1);
        wait_idle();

        // R2: remaining opcodes
        expect_start(3'd1, 10'd513, 1'b1, D_XFER, "R2");
        spi_send(8'h55, 10'd513, 32, 0);
        wait_idle();
        expect_start(3'd2, 10'd700, 1'b0, D_CMP, "R2");
        spi_send(8'h60, 10'd700, 32, 1);
        wait_idle();
        expect_start(3'd3, 10'd401, 1'b1, D_PE, "R2");
        spi_send(8'h86, 10'd401, 32, 0);
        wait_idle();
        expect_start(3'd4, 10'd290, 1'b1, D_PK, "R2");
        spi_send(8'h89, 10'd290, 32, 0);
        wait_idle();
        expect_start(3'd5, 10'd999, 1'b1, D_MM, "R2");
        spi_send(8'h85, 10'd999, 32, 0);
        wait_idle();

        // R7: write protect
        wp_n = 1'b0;
        tick(6);
        expect_reject("R7");
        spi_send(8'h83, 10'd255, 32, 0);
        check(!busy, "R7", $sformatf("busy=%0d exp 0", busy));
        expect_start(3'd3, 10'd256, 1'b0, D_PE, "R7");
        spi_send(8'h83, 10'd256, 32, 0);
        wait_idle();
        expect_reject("R7");
        spi_send(8'h58, 10'd0, 32, 0);
        expect_start(3'd1, 10'd0, 1'b0, D_XFER, "R7");
        spi_send(8'h53, 10'd0, 32, 0);
        wait_idle();
        expect_start(3'd2, 10'd100, 1'b1, D_CMP, "R7");
        spi_send(8'h61, 10'd100, 32, 0);
        wait_idle();
        wp_n = 1'b1;
        tick(6);
        expect_start(3'd4, 10'd0, 1'b0, D_PK, "R7");
        spi_send(8'h88, 10'd0, 32, 0);
        wait_idle();

        // R8: short frame dropped, long frame uses first 32 bits
        spi_send(8'h58, 10'd77, 31, 0);
        check(!busy && sb.size() == 0, "R8", $sformatf("busy=%0d pending=%0d exp 0 0", busy, sb.size()));
        expect_start(3'd5, 10'd5, 1'b0, D_MM, "R8");
        spi_send(8'h82, 10'd5, 48, 0);
        wait_idle();

        // R11: unknown opcode
        spi_send(8'hFF, 10'd1, 32, 0);
        check(!busy && !op_start && !cmd_rejected && op_kind == 3'd5 && op_page == 10'd5, "R11",
              $sformatf("busy=%0d kind=%0d page=%0d exp 0 5 5", busy, op_kind, op_page));
        // R6: buffer read while idle
        spi_send(8'h56, 10'd3, 32, 1);
        check(!busy && sb.size() == 0, "R6", $sformatf("busy=%0d pending=%0d exp 0 0", busy, sb.size()));

        tick(20);
        check(sb.size() == 0 && !measuring, "R3", $sformatf("pending=%0d exp 0", sb.size()));
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule